// File: doc/BRIEF.md
# Host Parallel-Bus Read Port with Direct FIFO Drain

This block sits behind the pads of an asynchronous, active-low host parallel bus. It watches the chip select and the read strobe, the word address bits and a FIFO-select input. For each read cycle it decides whether the host is draining the receive FIFO directly or reading the register map. It returns a 16-bit word, together with an output enable that the pad ring uses to drive the shared data bus.

Both strobes pass through a two-flop synchronizer into the local clock. The address and FIFO-select are captured in the clock cycle where the synchronized strobes first show a cycle. When FIFO-select is high, no address bit takes part in the decode: the access returns the head word of the receive FIFO. One FIFO entry is removed when the cycle ends, so the word the host sees stays fixed for the whole strobe. This lets a host that increments its address on every access stream a whole packet out of one address window. When FIFO-select is low, the read goes to a small register stub that is decoded from the full word address.

Top module: `hpio_rd_port`

## Requirements
- R1: A read cycle begins only when the synchronized chip select and read strobe are both low. Either strobe low on its own never raises `data_oe`, whichever of the two fell first.
- R2: A cycle ends as soon as either strobe returns high. `data_oe` then falls, whichever strobe rose first.
- R3: With `fifo_sel` high at cycle start, `data_out` carries the FIFO head word (`fifo_rdata`). No bit of `addr` changes the result.
- R4: A direct-FIFO cycle on a non-empty FIFO raises `fifo_pop` for exactly one clock. The pulse comes in the cycle where `data_oe` has already fallen.
- R5: Throughout a cycle, `data_out` holds the value captured at cycle start, even if `fifo_rdata`, `addr` or `fifo_sel` change.
- R6: A direct-FIFO cycle that starts with `fifo_empty` high returns 0x0000 and does not pop. It also sets `underrun`, which stays high until reset.
- R7: With `fifo_sel` low at cycle start, the read never pops. Let the word index be `addr[7:1]`. An index below 8 returns 0xA000 OR index; any other index returns 0x0000.
- R8: In reset and after it, `data_oe`, `fifo_pop` and `underrun` are 0 and `data_out` is 0x0000.
- R9: While `data_oe` is low, `data_out` is 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Host chip select, active low, asynchronous |
| rd_n | input | 1 | Host read strobe, active low, asynchronous |
| addr | input | 7 | Host word address bits 7..1 |
| fifo_sel | input | 1 | High selects the direct receive-FIFO read |
| fifo_rdata | input | 16 | Head word of the receive FIFO |
| fifo_empty | input | 1 | Receive FIFO holds no word |
| fifo_pop | output | 1 | One-clock pulse that removes the head word |
| data_out | output | 16 | Read data toward the pad |
| data_oe | output | 1 | Drive enable for the data pad |
| underrun | output | 1 | Sticky flag: a direct read found the FIFO empty |

## Verification
Each port shows a wrong internal state in its own way:
- A captured flag that is wrong sends the read to the other path. The host sees a stub word instead of FIFO data, or the reverse, as soon as `data_oe` rises, which is three clocks after the second strobe falls.
- A wrong cycle-tracking register shows up as `data_oe` rising on a single strobe, or not falling three clocks after a strobe rises.
- A wrong pop decision shows up as extra or missing pops. These make the host see the wrong word on the next direct read. A missing underrun shows up on `underrun` at the same edge where `data_oe` rises.

// File: rtl/hpio_pkg.sv
package hpio_pkg;
    localparam int DATA_W    = 16;
    localparam int ADDR_W    = 7;
    localparam int STUB_REGS = 8;
    localparam logic [DATA_W-1:0] STUB_TAG = 16'hA000;

    typedef struct packed {
        logic              direct;
        logic              empty;
        logic [DATA_W-1:0] word;
    } capture_t;

    function automatic logic [DATA_W-1:0] stub_word(input logic [ADDR_W-1:0] idx);
        logic [DATA_W-1:0] w;
        w = '0;
        if (int'(idx) < STUB_REGS)
            w = STUB_TAG | DATA_W'(idx);
        return w;
    endfunction
endpackage

// File: rtl/hpio_sync.sv
module hpio_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar b = 0; b < W; b++) begin : g_bit
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[STAGES-2:0], d[b]};
        end
        assign q[b] = chain[STAGES-1];
    end
endmodule

// File: rtl/hpio_cycle_ctl.sv
module hpio_cycle_ctl (
    input  logic clk,
    input  logic rst,
    input  logic cs_s,
    input  logic rd_s,
    output logic active_q,
    output logic start_p,
    output logic end_p
);
    logic active;
    assign active  = ~cs_s & ~rd_s;
    assign start_p = active & ~active_q;
    assign end_p   = ~active & active_q;

    always_ff @(posedge clk) begin
        if (rst) active_q <= 1'b0;
        else     active_q <= active;
    end
endmodule

// File: rtl/hpio_reg_stub.sv
module hpio_reg_stub
    import hpio_pkg::*;
(
    input  logic [ADDR_W-1:0] idx,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] table_w [STUB_REGS];
    for (genvar i = 0; i < STUB_REGS; i++) begin : g_reg
        assign table_w[i] = stub_word(ADDR_W'(i));
    end
    always_comb begin
        rdata = '0;
        for (int i = 0; i < STUB_REGS; i++)
            if (idx == ADDR_W'(i)) rdata = table_w[i];
    end
endmodule

// File: rtl/hpio_rd_port.sv
module hpio_rd_port
    import hpio_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              rd_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              fifo_sel,
    input  logic [DATA_W-1:0] fifo_rdata,
    input  logic              fifo_empty,
    output logic              fifo_pop,
    output logic [DATA_W-1:0] data_out,
    output logic              data_oe,
    output logic              underrun
);
    logic [1:0]        strobe_s;
    logic              active_q, start_p, end_p;
    logic [DATA_W-1:0] stub_rdata;
    capture_t          cap_q, cap_d;
    logic              pop_q, urun_q;

    hpio_sync #(.W(2), .STAGES(2)) u_sync (
        .clk(clk), .rst(rst), .d({cs_n, rd_n}), .q(strobe_s)
    );

    hpio_cycle_ctl u_ctl (
        .clk(clk), .rst(rst), .cs_s(strobe_s[1]), .rd_s(strobe_s[0]),
        .active_q(active_q), .start_p(start_p), .end_p(end_p)
    );

    hpio_reg_stub u_stub (.idx(addr), .rdata(stub_rdata));

    always_comb begin
        cap_d.direct = fifo_sel;
        cap_d.empty  = fifo_sel & fifo_empty;
        if (!fifo_sel)       cap_d.word = stub_rdata;
        else if (fifo_empty) cap_d.word = '0;
        else                 cap_d.word = fifo_rdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_q  <= '0;
            pop_q  <= 1'b0;
            urun_q <= 1'b0;
        end else begin
            if (start_p) begin
                cap_q  <= cap_d;
                urun_q <= urun_q | cap_d.empty;
            end
            pop_q <= end_p & cap_q.direct & ~cap_q.empty;
        end
    end

    assign fifo_pop = pop_q;
    assign data_oe  = active_q;
    assign data_out = active_q ? cap_q.word : '0;
    assign underrun = urun_q;
endmodule

// File: rtl/hpio_rd_port_chk.sv
module hpio_rd_port_chk
    import hpio_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              fifo_pop,
    input logic [DATA_W-1:0] data_out,
    input logic              data_oe,
    input logic              underrun
);
    p_pop_after_cycle_r4: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |-> !data_oe);
    p_pop_single_r4: assert property (@(posedge clk) disable iff (rst)
        fifo_pop |=> !fifo_pop);
    p_data_stable_r5: assert property (@(posedge clk) disable iff (rst)
        (data_oe && $past(data_oe)) |-> $stable(data_out));
    p_underrun_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        underrun |=> underrun);
    p_underrun_zero_r6: assert property (@(posedge clk) disable iff (rst)
        $rose(underrun) |-> (data_oe && data_out == '0));
    p_idle_zero_r9: assert property (@(posedge clk) disable iff (rst)
        !data_oe |-> data_out == '0);
endmodule

bind hpio_rd_port hpio_rd_port_chk u_chk (
    .clk(clk), .rst(rst), .fifo_pop(fifo_pop), .data_out(data_out),
    .data_oe(data_oe), .underrun(underrun)
);

// File: tb/hpio_rd_port_tb.sv
module hpio_rd_port_tb;
    logic        clk = 0, rst = 1;
    logic        cs_n = 1, rd_n = 1, fifo_sel = 0;
    logic [6:0]  addr = 0;
    logic [15:0] fifo_rdata;
    logic        fifo_empty, fifo_pop, data_oe, underrun;
    logic [15:0] data_out;

    logic [15:0] mem [64];
    int rdptr = 0, wrcnt = 0, pops = 0;
    int checks = 0, fails = 0, cyc = 0;
    bit done = 0;

    always #4 clk = ~clk;   // 125 MHz

    hpio_rd_port u_dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .addr(addr),
        .fifo_sel(fifo_sel), .fifo_rdata(fifo_rdata), .fifo_empty(fifo_empty),
        .fifo_pop(fifo_pop), .data_out(data_out), .data_oe(data_oe), .underrun(underrun)
    );

    assign fifo_rdata = mem[rdptr % 64];
    assign fifo_empty = (rdptr == wrcnt);

    always @(posedge clk) if (!rst && fifo_pop) begin
        rdptr <= rdptr + 1;
        pops  <= pops + 1;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            fails = fails + 1; checks = checks + 1;
            $display("FAIL watchdog: act=running exp=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    function automatic logic [15:0] exp_stub(input logic [6:0] a);
        return (a < 7'd8) ? (16'hA000 | {9'd0, a}) : 16'h0000;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic push(input logic [15:0] w);
        mem[wrcnt % 64] = w;
        wrcnt++;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One read: order picks which strobe falls/rises first; disturb changes inputs mid-cycle
    task automatic do_read(input logic [6:0] a, input logic sel, input bit cs_first,
                           input bit rise_cs_first, input bit disturb);
        logic [15:0] exp;
        int p0;
        bit was_empty;
        @(negedge clk);
        addr = a; fifo_sel = sel;
        was_empty = (rdptr == wrcnt);
        exp = sel ? (was_empty ? 16'h0 : mem[rdptr % 64]) : exp_stub(a);
        p0 = pops;
        if (cs_first) cs_n = 0; else rd_n = 0;
        wait_n(4);
        chk("R1 single strobe", {31'd0, data_oe}, 32'd0);
        if (cs_first) rd_n = 0; else cs_n = 0;
        wait_n(4);
        chk("R1 oe in cycle", {31'd0, data_oe}, 32'd1);
        chk(sel ? "R3 fifo word" : "R7 stub word", {16'd0, data_out}, {16'd0, exp});
        if (sel && was_empty) chk("R6 underrun set", {31'd0, underrun}, 32'd1);
        if (disturb) begin
            addr = ~a; fifo_sel = ~sel;
            mem[rdptr % 64] = ~mem[rdptr % 64];
            wait_n(2);
            chk("R5 stable", {16'd0, data_out}, {16'd0, exp});
        end
        if (rise_cs_first) cs_n = 1; else rd_n = 1;
        wait_n(5);
        chk("R2 oe drops", {31'd0, data_oe}, 32'd0);
        chk("R9 idle data", {16'd0, data_out}, 32'd0);
        cs_n = 1; rd_n = 1;
        wait_n(3);
        if (sel && !was_empty) chk("R4 one pop", pops - p0, 1);
        else if (sel)          chk("R6 no pop", pops - p0, 0);
        else                   chk("R7 no pop", pops - p0, 0);
        fifo_sel = 0;
    endtask

    initial begin
        void'($urandom(32'd1234));
        wait_n(4);
        chk("R8 oe reset", {31'd0, data_oe}, 32'd0);
        chk("R8 data reset", {16'd0, data_out}, 32'd0);
        chk("R8 pop reset", {31'd0, fifo_pop}, 32'd0);
        rst = 0;
        wait_n(3);
        chk("R8 underrun after reset", {31'd0, underrun}, 32'd0);
        // directed: R7 stub in and out of range
        do_read(7'd3, 0, 1, 1, 0);
        do_read(7'd7, 0, 0, 0, 0);
        do_read(7'd8, 0, 1, 0, 0);
        do_read(7'h7F, 0, 0, 1, 1);
        // directed: R3 across address extremes, R5 disturbance
        push(16'h1234); push(16'hBEEF); push(16'h0001);
        do_read(7'h00, 1, 1, 1, 0);
        do_read(7'h7F, 1, 0, 1, 1);
        do_read(7'h55, 1, 1, 0, 0);
        chk("R6 not yet underrun", {31'd0, underrun}, 32'd0);
        // R6 empty
        do_read(7'h10, 1, 0, 0, 0);
        chk("R6 sticky", {31'd0, underrun}, 32'd1);
        push(16'hCAFE);
        do_read(7'h20, 1, 1, 1, 0);
        chk("R6 sticky after data", {31'd0, underrun}, 32'd1);
        // random mix
        for (int i = 0; i < 60; i++) begin
            int r;
            r = $urandom_range(0, 3);
            if (r != 0 && (wrcnt - rdptr) < 60) push(16'($urandom));
            do_read(7'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule